// File: doc/BRIEF.md
# Unordered record fetch engine

The engine takes one fetch command and gathers a run of equal-sized records from a word-addressed memory. A command names the address of the first record, the record length in words and the number of records. Record k covers the words from base + k*size up to base + k*size + size - 1. The engine sends single-word reads to a backend. Each read carries a tag, and the backend may answer the reads in any order and after any delay. Returned words go into a small pool of record slots. Once every word of a slot has arrived, the record is streamed out on a ready/valid port.

Records leave in the order in which they become complete. A slow region at the front of the range therefore does not hold back records behind it that are already fast to read. Inside a record, the words always leave back to back, lowest address first, and no word of any other record is placed between them. A record is allocated a slot before any of its reads go out, so the number of records in flight never exceeds the number of slots.

Top module: `rec_fetch_top`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress. A command is taken on `cmd_valid && cmd_ready` and carries the base address, the record size (1 to MAX_WORDS) and the record count.
- R2: Every read address lies in the range of a requested record. The read tag is {slot, word index}, with the word index in the low log2(MAX_WORDS) bits, and it equals the address offset inside the record. Each output word equals the memory word at base + record*size + position.
- R3: Responses are accepted one per cycle with no ready signal, in any order and after any latency. A response is matched to its word by its tag.
- R4: Every record is delivered exactly once, with `out_rec` giving its index. Its words are contiguous and in ascending address order, and `out_last` is high on its final word only.
- R5: A complete record is streamed without waiting for an earlier record that is still incomplete.
- R6: When several complete records are waiting, the one with the lowest record index (the earliest issued) is streamed first.
- R7: While `out_valid && !out_ready`, the output word, record index and last flag stay unchanged. While `rd_req_valid && !rd_req_ready`, the read address and tag stay unchanged.
- R8: At most SLOTS records are in flight at once (reads started but not fully delivered).
- R9: `done` is a one-cycle pulse in the cycle after the final word of the final record is accepted, and `cmd_ready` is high again in that same cycle.
- R10: A command with a record count of zero issues no reads and produces no output. `done` pulses in the cycle after the command is taken.
- R11: During reset, `cmd_ready` is high and `out_valid`, `rd_req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_base | input | ADDR_W | Word address of record 0 |
| cmd_size | input | log2(MAX_WORDS)+1 | Words per record |
| cmd_count | input | CNT_W | Number of records |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Backend takes the request |
| rd_req_addr | output | ADDR_W | Word address to read |
| rd_req_tag | output | log2(SLOTS)+log2(MAX_WORDS) | {slot, word index} |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_tag | input | log2(SLOTS)+log2(MAX_WORDS) | Tag of the returned word |
| rd_rsp_data | input | DATA_W | Returned word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DATA_W | Record word |
| out_rec | output | CNT_W | Record index of the word |
| out_last | output | 1 | Final word of the record |
| done | output | 1 | Command finished (one-cycle pulse) |

## Verification
Two events can land in the same cycle: a read response being written into one slot, and the release of another slot on its last output word, which is often followed at once by the reuse of that slot for a new record. The case is provoked with full-size records, more records than slots, random backend latency and random backpressure on both streams, so that responses keep arriving while slots are freed and claimed again. It is judged by comparing every delivered word with the memory value the bench computes from its address, and by confirming that each record index appears exactly once with its words unbroken. A separate scenario with a slow first record and a blocked consumer fixes the exact delivery order expected under completion-order and oldest-first selection.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  // issue engine: waiting for a free slot, or sending the words of one record
  typedef enum logic {ISS_IDLE, ISS_RUN} iss_st_e;
  // output streamer: choosing a record, or sending its words
  typedef enum logic {STR_IDLE, STR_SEND} str_st_e;
endpackage

// File: rtl/rfe_slots.sv
module rfe_slots #(
  parameter int SLOTS     = 4,
  parameter int MAX_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int WIDX_W   = $clog2(MAX_WORDS),
  localparam int SIZE_W   = WIDX_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SIZE_W-1:0]             rec_size,
  input  logic                          alloc_en,
  input  logic [SLOT_W-1:0]             alloc_slot,
  input  logic [CNT_W-1:0]              alloc_rec,
  input  logic                          free_en,
  input  logic [SLOT_W-1:0]             free_slot,
  input  logic                          wr_en,
  input  logic [SLOT_W-1:0]             wr_slot,
  input  logic [WIDX_W-1:0]             wr_word,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [SLOT_W-1:0]             rd_slot,
  input  logic [WIDX_W-1:0]             rd_word,
  output logic [DATA_W-1:0]             rd_data,
  output logic [SLOTS-1:0]              used_o,
  output logic [SLOTS-1:0]              full_o,
  output logic [SLOTS-1:0][CNT_W-1:0]   rec_o
);

  logic [SLOTS-1:0]                  used_q, used_d;
  logic [SLOTS-1:0][CNT_W-1:0]       rec_q, rec_d;
  logic [SLOTS-1:0][MAX_WORDS-1:0]   vld_q, vld_d;
  logic [MAX_WORDS-1:0]              wmask;
  logic [DATA_W-1:0]                 store [SLOTS][MAX_WORDS];

  // word positions that belong to a record of the current size
  always_comb begin
    for (int w = 0; w < MAX_WORDS; w++) begin
      wmask[w] = (SIZE_W'(w) < rec_size);
    end
  end

  always_comb begin
    used_d = used_q;
    rec_d  = rec_q;
    vld_d  = vld_q;
    if (alloc_en) begin
      used_d[alloc_slot] = 1'b1;
      rec_d[alloc_slot]  = alloc_rec;
      vld_d[alloc_slot]  = '0;
    end
    if (free_en) begin
      used_d[free_slot] = 1'b0;
    end
    if (wr_en) begin
      vld_d[wr_slot][wr_word] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      rec_q  <= '0;
      vld_q  <= '0;
    end else begin
      used_q <= used_d;
      rec_q  <= rec_d;
      vld_q  <= vld_d;
    end
  end

  // data array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_slot][wr_word] <= wr_data;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_full
    assign full_o[s] = used_q[s] & (&(vld_q[s] | ~wmask));
  end

  assign used_o  = used_q;
  assign rec_o   = rec_q;
  assign rd_data = store[rd_slot][rd_word];

endmodule

// File: rtl/rfe_issue.sv
module rfe_issue
  import rfe_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SLOTS     = 4,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int WIDX_W   = $clog2(MAX_WORDS),
  localparam int SIZE_W   = WIDX_W + 1,
  localparam int TAG_W    = SLOT_W + WIDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base,
  input  logic [SIZE_W-1:0]   rec_size,
  input  logic [CNT_W-1:0]    rec_count,
  input  logic [SLOTS-1:0]    used,
  output logic                alloc_en,
  output logic [SLOT_W-1:0]   alloc_slot,
  output logic [CNT_W-1:0]    alloc_rec,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [ADDR_W-1:0]   rd_req_addr,
  output logic [TAG_W-1:0]    rd_req_tag
);

  iss_st_e             st_q, st_d;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  logic [WIDX_W-1:0]   word_q, word_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [CNT_W-1:0]    nrec_q, nrec_d;
  logic [ADDR_W-1:0]   naddr_q, naddr_d;
  logic                has_free;
  logic [SLOT_W-1:0]   free_idx;
  logic                last_word;

  // lowest-numbered empty slot
  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!used[s]) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(s);
      end
    end
  end

  assign last_word = ({1'b0, word_q} == rec_size - SIZE_W'(1));

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    word_d   = word_q;
    addr_d   = addr_q;
    nrec_d   = nrec_q;
    naddr_d  = naddr_q;
    alloc_en = 1'b0;
    if (start) begin
      nrec_d  = '0;
      naddr_d = base;
    end else begin
      unique case (st_q)
        ISS_IDLE: begin
          if (has_free && (nrec_q < rec_count)) begin
            alloc_en = 1'b1;
            st_d     = ISS_RUN;
            slot_d   = free_idx;
            word_d   = '0;
            addr_d   = naddr_q;
            naddr_d  = naddr_q + ADDR_W'(rec_size);
            nrec_d   = nrec_q + CNT_W'(1);
          end
        end
        ISS_RUN: begin
          if (rd_req_ready) begin
            if (last_word) begin
              st_d = ISS_IDLE;
            end else begin
              word_d = word_q + WIDX_W'(1);
              addr_d = addr_q + ADDR_W'(1);
            end
          end
        end
        default: st_d = ISS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ISS_IDLE;
      slot_q  <= '0;
      word_q  <= '0;
      addr_q  <= '0;
      nrec_q  <= '0;
      naddr_q <= '0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      word_q  <= word_d;
      addr_q  <= addr_d;
      nrec_q  <= nrec_d;
      naddr_q <= naddr_d;
    end
  end

  assign alloc_slot   = free_idx;
  assign alloc_rec    = nrec_q;
  assign rd_req_valid = (st_q == ISS_RUN);
  assign rd_req_addr  = addr_q;
  assign rd_req_tag   = {slot_q, word_q};

endmodule

// File: rtl/rfe_stream.sv
module rfe_stream
  import rfe_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int MAX_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int WIDX_W   = $clog2(MAX_WORDS),
  localparam int SIZE_W   = WIDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SIZE_W-1:0]            rec_size,
  input  logic [SLOTS-1:0]             full,
  input  logic [SLOTS-1:0][CNT_W-1:0]  rec,
  output logic [SLOT_W-1:0]            rd_slot,
  output logic [WIDX_W-1:0]            rd_word,
  input  logic [DATA_W-1:0]            rd_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DATA_W-1:0]            out_data,
  output logic [CNT_W-1:0]             out_rec,
  output logic                         out_last,
  output logic                         free_en,
  output logic [SLOT_W-1:0]            free_slot
);

  str_st_e            st_q, st_d;
  logic [SLOT_W-1:0]  cur_q, cur_d;
  logic [WIDX_W-1:0]  word_q, word_d;
  logic               pick_v;
  logic [SLOT_W-1:0]  pick_s;
  logic [CNT_W-1:0]   pick_r;
  logic               fire;

  // complete slot holding the lowest record index (issued earliest)
  always_comb begin
    pick_v = 1'b0;
    pick_s = '0;
    pick_r = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (full[s] && (!pick_v || (rec[s] < pick_r))) begin
        pick_v = 1'b1;
        pick_s = SLOT_W'(s);
        pick_r = rec[s];
      end
    end
  end

  assign out_valid = (st_q == STR_SEND);
  assign out_last  = ({1'b0, word_q} == rec_size - SIZE_W'(1));
  assign fire      = out_valid & out_ready;

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    word_d = word_q;
    unique case (st_q)
      STR_IDLE: begin
        if (pick_v) begin
          st_d   = STR_SEND;
          cur_d  = pick_s;
          word_d = '0;
        end
      end
      STR_SEND: begin
        if (fire) begin
          if (out_last) begin
            st_d = STR_IDLE;
          end else begin
            word_d = word_q + WIDX_W'(1);
          end
        end
      end
      default: st_d = STR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= STR_IDLE;
      cur_q  <= '0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      word_q <= word_d;
    end
  end

  assign rd_slot   = cur_q;
  assign rd_word   = word_q;
  assign out_data  = rd_data;
  assign out_rec   = rec[cur_q];
  assign free_en   = fire & out_last;
  assign free_slot = cur_q;

endmodule

// File: rtl/rec_fetch_top.sv
module rec_fetch_top #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SLOTS     = 4,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int WIDX_W   = $clog2(MAX_WORDS),
  localparam int SIZE_W   = WIDX_W + 1,
  localparam int TAG_W    = SLOT_W + WIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_base,
  input  logic [SIZE_W-1:0]  cmd_size,
  input  logic [CNT_W-1:0]   cmd_count,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [TAG_W-1:0]   rd_req_tag,
  input  logic               rd_rsp_valid,
  input  logic [TAG_W-1:0]   rd_rsp_tag,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [CNT_W-1:0]   out_rec,
  output logic               out_last,
  output logic               done
);

  logic                         busy_q, busy_d;
  logic                         done_q, done_d;
  logic [CNT_W-1:0]             left_q, left_d;
  logic [SIZE_W-1:0]            size_q, size_d;
  logic [CNT_W-1:0]             count_q, count_d;
  logic                         start;

  logic                         alloc_en;
  logic [SLOT_W-1:0]            alloc_slot;
  logic [CNT_W-1:0]             alloc_rec;
  logic                         free_en;
  logic [SLOT_W-1:0]            free_slot;
  logic [SLOT_W-1:0]            rd_slot;
  logic [WIDX_W-1:0]            rd_word;
  logic [DATA_W-1:0]            rd_data;
  logic [SLOTS-1:0]             used;
  logic [SLOTS-1:0]             full;
  logic [SLOTS-1:0][CNT_W-1:0]  slot_rec;

  assign cmd_ready = ~busy_q;
  assign start     = cmd_valid & cmd_ready;
  assign done      = done_q;

  // command bookkeeping: records still to deliver, completion pulse
  always_comb begin
    busy_d  = busy_q;
    left_d  = left_q;
    size_d  = size_q;
    count_d = count_q;
    done_d  = 1'b0;
    if (start) begin
      size_d  = cmd_size;
      count_d = cmd_count;
      left_d  = cmd_count;
      busy_d  = (cmd_count != '0);
      done_d  = (cmd_count == '0);
    end else if (free_en) begin
      left_d = left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      left_q  <= '0;
      size_q  <= '0;
      count_q <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      left_q  <= left_d;
      size_q  <= size_d;
      count_q <= count_d;
    end
  end

  rfe_issue #(
    .ADDR_W(ADDR_W), .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
  ) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .base        (cmd_base),
    .rec_size    (size_q),
    .rec_count   (count_q),
    .used        (used),
    .alloc_en    (alloc_en),
    .alloc_slot  (alloc_slot),
    .alloc_rec   (alloc_rec),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .rd_req_tag  (rd_req_tag)
  );

  rfe_slots #(
    .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_size  (size_q),
    .alloc_en  (alloc_en),
    .alloc_slot(alloc_slot),
    .alloc_rec (alloc_rec),
    .free_en   (free_en),
    .free_slot (free_slot),
    .wr_en     (rd_rsp_valid),
    .wr_slot   (rd_rsp_tag[TAG_W-1:WIDX_W]),
    .wr_word   (rd_rsp_tag[WIDX_W-1:0]),
    .wr_data   (rd_rsp_data),
    .rd_slot   (rd_slot),
    .rd_word   (rd_word),
    .rd_data   (rd_data),
    .used_o    (used),
    .full_o    (full),
    .rec_o     (slot_rec)
  );

  rfe_stream #(
    .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .rec_size (size_q),
    .full     (full),
    .rec      (slot_rec),
    .rd_slot  (rd_slot),
    .rd_word  (rd_word),
    .rd_data  (rd_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_rec  (out_rec),
    .out_last (out_last),
    .free_en  (free_en),
    .free_slot(free_slot)
  );

endmodule

// File: rtl/rfe_chk.sv
module rfe_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SLOTS     = 4,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = 8,
  localparam int TAG_W    = $clog2(SLOTS) + $clog2(MAX_WORDS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [CNT_W-1:0]   cmd_count,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic [TAG_W-1:0]   rd_req_tag,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic [CNT_W-1:0]   out_rec,
  input logic               out_last,
  input logic               done
);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_rec) && $stable(out_last));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_tag));

  // R4
  rec_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && $stable(out_rec));

  // R1
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_count != '0) |=> !cmd_ready);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !out_valid && !rd_req_valid);

  // R10
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_count == '0) |=> done && !rd_req_valid && !out_valid);

endmodule

bind rec_fetch_top rfe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_rec_fetch_top.sv
module tb_rec_fetch_top;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int SLOTS     = 4;
  localparam int MAX_WORDS = 8;
  localparam int CNT_W     = 8;
  localparam int WIDX_W    = 3;
  localparam int SIZE_W    = 4;
  localparam int TAG_W     = 5;
  localparam int PEND      = 64;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready;
  logic [ADDR_W-1:0] cmd_base;
  logic [SIZE_W-1:0] cmd_size;
  logic [CNT_W-1:0]  cmd_count;
  logic rd_req_valid, rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [TAG_W-1:0]  rd_req_tag;
  logic rd_rsp_valid;
  logic [TAG_W-1:0]  rd_rsp_tag;
  logic [DATA_W-1:0] rd_rsp_data;
  logic out_valid, out_ready, out_last, done;
  logic [DATA_W-1:0] out_data;
  logic [CNT_W-1:0]  out_rec;

  rec_fetch_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
                  .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [DATA_W-1:0] mem_word(input int a);
    logic [15:0] x;
    x = 16'(a);
    return {~x, x};
  endfunction

  // scenario settings
  int base_v, size_v, count_v;
  int lat_mode, slow_lo, slow_hi;
  int obp_mode, rbp_mode, hold_cnt;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  // monitor state
  bit seen [256];
  bit iss [256];
  int got_order [256];
  int n_got, cur_rec, cur_idx, outst, max_out, n_done, n_req, n_words;
  bit exp_done, busy_exp, hold_prev, prev_last;
  logic [DATA_W-1:0] prev_data;
  logic [CNT_W-1:0]  prev_rec;

  // backend pending reads
  bit p_v [PEND];
  int p_d [PEND];
  logic [TAG_W-1:0] p_tag [PEND];
  int p_a [PEND];

  function automatic int latency(input int a);
    case (lat_mode)
      0: return 2;
      1: return (a >= slow_lo && a < slow_hi) ? 40 : 2;
      default: return 1 + int'(lfsr[13:10]);
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (obp_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[2] | lfsr[5];
        default: out_ready = (hold_cnt == 0);
      endcase
      if (hold_cnt > 0) hold_cnt--;
      rd_req_ready = (rbp_mode != 0) ? (lfsr[7] | lfsr[9]) : 1'b1;

      // R7: output stalled last edge must be unchanged
      if (hold_prev)
        chk(out_valid && out_data == prev_data && out_rec == prev_rec && out_last == prev_last,
            "R7", "held output", out_data, prev_data);

      if (exp_done) begin
        chk(done === 1'b1, "R9", "done pulse", done, 1);
        chk(cmd_ready === 1'b1, "R9", "ready with done", cmd_ready, 1);
        exp_done = 0;
        busy_exp = 0;
        n_done++;
      end else if (done) begin
        chk(0, "R9", "unexpected done", 1, 0);
      end
      if (busy_exp) chk(!cmd_ready, "R1", "cmd_ready while busy", cmd_ready, 0);

      if (cmd_valid && cmd_ready) begin
        if (cmd_count == 0) exp_done = 1;
        else busy_exp = 1;
      end

      if (out_valid && out_ready) begin
        n_words++;
        if (cur_idx == 0) begin
          chk(int'(out_rec) < count_v && !seen[out_rec], "R4", "record index fresh", out_rec, count_v);
          seen[out_rec] = 1;
          got_order[n_got] = int'(out_rec);
          n_got++;
          cur_rec = int'(out_rec);
        end else begin
          chk(int'(out_rec) == cur_rec, "R4", "record interleaved", out_rec, cur_rec);
        end
        chk(out_data == mem_word(base_v + cur_rec * size_v + cur_idx), "R2", "word data",
            out_data, mem_word(base_v + cur_rec * size_v + cur_idx));
        chk(out_last == (cur_idx == size_v - 1), "R4", "last flag", out_last, cur_idx == size_v - 1);
        if (cur_idx == size_v - 1) begin
          cur_idx = 0;
          outst--;
          if (n_got == count_v) exp_done = 1;
        end else begin
          cur_idx++;
        end
      end
      hold_prev = out_valid && !out_ready;
      prev_data = out_data;
      prev_rec  = out_rec;
      prev_last = out_last;

      // backend response (R3: any order, one per cycle)
      begin
        int sel;
        sel = -1;
        for (int i = 0; i < PEND; i++) if (p_v[i] && p_d[i] > 0) p_d[i]--;
        for (int i = 0; i < PEND; i++) if (p_v[i] && p_d[i] == 0) sel = i;
        rd_rsp_valid = 1'b0;
        if (sel >= 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_tag   = p_tag[sel];
          rd_rsp_data  = mem_word(p_a[sel]);
          p_v[sel]     = 0;
        end
      end

      if (rd_req_valid && rd_req_ready) begin
        int off, r, slotn;
        n_req++;
        off = int'(rd_req_addr) - base_v;
        r = off / size_v;
        chk(off >= 0 && r < count_v, "R2", "read address range", rd_req_addr, base_v);
        chk(int'(rd_req_tag[WIDX_W-1:0]) == off % size_v, "R2", "tag word index",
            rd_req_tag[WIDX_W-1:0], off % size_v);
        if (r >= 0 && r < 256 && !iss[r]) begin
          iss[r] = 1;
          outst++;
          if (outst > max_out) max_out = outst;
        end
        slotn = -1;
        for (int i = 0; i < PEND; i++) if (!p_v[i] && slotn < 0) slotn = i;
        if (slotn >= 0) begin
          p_v[slotn] = 1;
          p_d[slotn] = latency(int'(rd_req_addr));
          p_tag[slotn] = rd_req_tag;
          p_a[slotn] = int'(rd_req_addr);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d expected 0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic launch(input int b, input int s, input int c, input int lm,
                        input int ob, input int rb, input int hold);
    @(posedge clk); #3;
    base_v = b; size_v = s; count_v = c;
    lat_mode = lm; obp_mode = ob; rbp_mode = rb; hold_cnt = hold;
    for (int i = 0; i < 256; i++) begin seen[i] = 0; iss[i] = 0; end
    n_got = 0; cur_idx = 0; outst = 0; max_out = 0; n_done = 0; n_req = 0; n_words = 0;
    chk(cmd_ready, "R1", "ready before command", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_base  = ADDR_W'(b);
    cmd_size  = SIZE_W'(s);
    cmd_count = CNT_W'(c);
    @(posedge clk); #3;
    cmd_valid = 1'b0;
    for (int i = 0; i < 5000 && n_done == 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #3;
  endtask

  task automatic end_checks(input string tag);
    chk(n_done == 1, "R9", {tag, " done count"}, n_done, 1);
    chk(n_got == count_v, "R4", {tag, " records delivered"}, n_got, count_v);
    chk(n_words == count_v * size_v, "R4", {tag, " words delivered"}, n_words, count_v * size_v);
    chk(max_out <= SLOTS, "R8", {tag, " records in flight"}, max_out, SLOTS);
    chk(cmd_ready, "R1", {tag, " idle after done"}, cmd_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk(cmd_ready === 1'b1, "R11", "reset cmd_ready", cmd_ready, 1);
    chk(out_valid === 1'b0, "R11", "reset out_valid", out_valid, 0);
    chk(rd_req_valid === 1'b0, "R11", "reset rd_req_valid", rd_req_valid, 0);
    chk(done === 1'b0, "R11", "reset done", done, 0);
    @(posedge clk); #3;
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    launch(100, 3, 6, 0, 0, 0, 0);
    end_checks("basic");
  endtask

  // R5 R6: slow record 0, consumer blocked until all are complete
  task automatic t_reorder();
    slow_lo = 40; slow_hi = 42;
    launch(40, 2, 4, 1, 2, 0, 80);
    end_checks("reorder");
    chk(got_order[0] == 1, "R5", "first record out", got_order[0], 1);
    chk(got_order[1] == 0, "R6", "second record out", got_order[1], 0);
    chk(got_order[2] == 2, "R6", "third record out", got_order[2], 2);
    chk(got_order[3] == 3, "R6", "fourth record out", got_order[3], 3);
  endtask

  // R3 R7 R8: full-size records, random latency, backpressure on both sides
  task automatic t_stress();
    launch(16'h200, MAX_WORDS, 12, 2, 1, 1, 0);
    end_checks("stress");
  endtask

  task automatic t_single();
    launch(7, 1, 9, 2, 0, 1, 0);
    end_checks("single");
  endtask

  // R10
  task automatic t_zero();
    launch(300, 4, 0, 0, 0, 0, 0);
    chk(n_done == 1, "R10", "done on empty command", n_done, 1);
    chk(n_req == 0, "R10", "reads on empty command", n_req, 0);
    chk(n_words == 0, "R10", "words on empty command", n_words, 0);
  endtask

  initial begin
    cmd_valid = 1'b0; cmd_base = '0; cmd_size = '0; cmd_count = '0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_tag = '0; rd_rsp_data = '0;
    out_ready = 1'b0;
    base_v = 0; size_v = 1; count_v = 0; lat_mode = 0; slow_lo = 0; slow_hi = 0;
    obp_mode = 0; rbp_mode = 0; hold_cnt = 0;
    exp_done = 0; busy_exp = 0; hold_prev = 0;
    for (int i = 0; i < PEND; i++) p_v[i] = 0;
    t_reset();
    t_basic();
    t_reorder();
    t_stress();
    t_zero();
    t_single();
    t_basic();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule